// File: doc/BRIEF.md
# Software-Break Signature Bus Snooper

This block sits passively on the bus of an 8-bit processor with a 16-bit address space. It drives nothing on that bus. It watches the address, data, read/write and opcode-fetch strobe lines every bus cycle. When the processor fetches the break opcode, the block starts tracking the software-interrupt sequence. It records the byte the processor reads on the following cycle and discards. That byte is the signature, and the block uses it to trigger hardware responses in a test rig.

The block then follows the three stack writes that the sequence makes, which store the return high byte, the return low byte and the status byte. From these writes it rebuilds the pushed return address. On the status write it publishes several values together: the signature, the break address, the return address, and a flag saying whether the return address equals the break address plus two. The low byte of the published return address serves as a second identifier for the break site. The block also holds a programmable table of signature values. When a published signature matches an enabled table entry, the block raises an action output carrying the index of that entry.

The control is a five-state machine:
- ST_IDLE moves to ST_SIG on a break fetch.
- ST_SIG captures the signature and moves to ST_PUSH_HI.
- ST_PUSH_HI moves to ST_PUSH_LO on a stack write.
- ST_PUSH_LO moves to ST_PUSH_ST on a stack write.
- ST_PUSH_ST returns to ST_IDLE on a stack write and publishes the results.

From any state other than ST_IDLE, an opcode fetch aborts the sequence. The machine goes back to ST_IDLE, or to ST_SIG if that fetch is itself a break.

Top module: `brk_sig_snoop`

## Requirements
- R1: An opcode fetch starts a capture when `bus_sync`=1, `bus_rnw`=1 and `bus_data`=8'h00. An opcode fetch with any other data byte starts no capture, so no hit follows.
- R2: `sig_o` publishes the data byte read in the bus cycle right after the break fetch.
- R3: A stack write is a cycle with `bus_rnw`=0 and `bus_addr[15:8]`=8'h01. After the signature cycle, the first stack write gives the return high byte and the second gives the return low byte. The third stack write is the status push and completes the sequence. Any other cycles between these writes are ignored, and that includes writes outside page 8'h01. `ret_addr_o[7:0]` is the break-site identifier.
- R4: `hit_o` is high for exactly the one cycle that follows the clock edge sampling the status push.
- R5: `sig_o`, `brk_addr_o`, `ret_addr_o` and `ret_ok_o` change only together with a hit. Between hits they hold their values.
- R6: `ret_ok_o` is 1 when the return address equals the break address plus 2, taken modulo 2^16. Otherwise it is 0.
- R7: The table has 8 entries. A cycle with `tbl_we`=1 writes `tbl_sig` and `tbl_on` into entry `tbl_idx`. `act_valid_o` pulses together with `hit_o` when the signature matches an enabled entry. `act_idx_o` is then the lowest matching index. Without a match, `act_valid_o`=0 and `act_idx_o`=0.
- R8: An opcode fetch seen before the status push ends the capture without a hit, and the published values stay as they were. If that fetch is a break, it starts a new capture.
- R9: A synchronous reset clears `hit_o`, `act_valid_o`, `act_idx_o`, all published values and every table enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus cycle per edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Observed address bus |
| bus_data | input | 8 | Observed data bus |
| bus_rnw | input | 1 | Observed read (1) / write (0) |
| bus_sync | input | 1 | Observed opcode-fetch strobe |
| tbl_we | input | 1 | Match-table write strobe |
| tbl_idx | input | 3 | Match-table entry to write |
| tbl_sig | input | 8 | Signature value for the entry |
| tbl_on | input | 1 | Enable bit for the entry |
| hit_o | output | 1 | One-cycle pulse when a break sequence completes |
| sig_o | output | 8 | Published signature byte |
| brk_addr_o | output | 16 | Published break opcode address |
| ret_addr_o | output | 16 | Published pushed return address |
| ret_ok_o | output | 1 | Return address equals break address plus 2 |
| act_valid_o | output | 1 | Action pulse: signature matched an enabled entry |
| act_idx_o | output | 3 | Index of the matching entry |

## Verification
The bench builds a break at address FFFF. A design that rebuilt the return address without 16-bit wraparound would report a mismatch there. It programs two enabled entries with the same signature, so a priority encoder that favoured the higher index would show up at once. It disables an entry whose signature matches, and it checks that no action follows. It places a non-stack write and a plain read between the pushes. A design that took any write as a push would then publish a wrong return high byte. Finally, it interrupts a sequence with an ordinary opcode fetch, and separately with a second break. A design that ignored the abort would raise a stale hit or overwrite the held values, and one that dropped the restart would miss the second break.

// File: rtl/brk_snoop_pkg.sv
package brk_snoop_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SIG,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_ST
    } snoop_st_e;
endpackage

// File: rtl/brk_seq_fsm.sv
module brk_seq_fsm
    import brk_snoop_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter logic [7:0] BRK_OP     = 8'h00,
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_rnw,
    input  logic              bus_sync,
    output logic              done_o,
    output logic [ADDR_W-1:0] brk_addr_o,
    output logic [DATA_W-1:0] sig_o,
    output logic [ADDR_W-1:0] ret_addr_o
);
    localparam int HI_W = ADDR_W - DATA_W;

    snoop_st_e st_q, st_d;
    logic is_brk, is_push;

    assign is_brk  = bus_sync && bus_rnw && (bus_data == DATA_W'(BRK_OP));
    assign is_push = !bus_rnw && (bus_addr[ADDR_W-1:DATA_W] == HI_W'(STACK_PAGE));

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (is_brk) st_d = ST_SIG;
            ST_SIG: begin
                if (bus_sync) st_d = is_brk ? ST_SIG : ST_IDLE;
                else          st_d = ST_PUSH_HI;
            end
            ST_PUSH_HI: begin
                if (bus_sync)     st_d = is_brk ? ST_SIG : ST_IDLE;
                else if (is_push) st_d = ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
                if (bus_sync)     st_d = is_brk ? ST_SIG : ST_IDLE;
                else if (is_push) st_d = ST_PUSH_ST;
            end
            ST_PUSH_ST: begin
                if (bus_sync)     st_d = is_brk ? ST_SIG : ST_IDLE;
                else if (is_push) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign done_o = (st_q == ST_PUSH_ST) && is_push && !bus_sync;

    // captured values
    always_ff @(posedge clk) begin
        if (rst) begin
            brk_addr_o <= '0;
            sig_o      <= '0;
            ret_addr_o <= '0;
        end else begin
            if (is_brk) brk_addr_o <= bus_addr;
            if (st_q == ST_SIG && !bus_sync) sig_o <= bus_data;
            if (st_q == ST_PUSH_HI && !bus_sync && is_push)
                ret_addr_o[ADDR_W-1:DATA_W] <= HI_W'(bus_data);
            if (st_q == ST_PUSH_LO && !bus_sync && is_push)
                ret_addr_o[DATA_W-1:0] <= bus_data;
        end
    end

    AST_FETCH_STARTS: assert property (@(posedge clk) disable iff (rst)
        is_brk |=> (st_q == ST_SIG)); // R1
    AST_SYNC_ENDS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (bus_sync && !is_brk) |=> (st_q == ST_IDLE)); // R8
endmodule

// File: rtl/brk_match_table.sv
module brk_match_table #(
    parameter int N_ENT  = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_sig,
    input  logic              wr_on,
    input  logic [DATA_W-1:0] key,
    output logic              match_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [DATA_W-1:0] ent_sig [N_ENT];
    logic [N_ENT-1:0]  ent_on;
    logic [N_ENT-1:0]  ent_hit;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_sig[g] <= '0;
                ent_on[g]  <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                ent_sig[g] <= wr_sig;
                ent_on[g]  <= wr_on;
            end
        end
        assign ent_hit[g] = ent_on[g] && (ent_sig[g] == key);
    end

    // lowest index wins
    always_comb begin
        match_o = 1'b0;
        idx_o   = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (ent_hit[i]) begin
                match_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

    AST_IDX_IS_ENABLED_MATCH: assert property (@(posedge clk) disable iff (rst)
        match_o |-> (ent_on[idx_o] && ent_sig[idx_o] == key)); // R7
endmodule

// File: rtl/brk_sig_snoop.sv
module brk_sig_snoop #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int N_ENT  = 8,
    parameter logic [7:0] STACK_PAGE = 8'h01,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_rnw,
    input  logic              bus_sync,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [DATA_W-1:0] tbl_sig,
    input  logic              tbl_on,
    output logic              hit_o,
    output logic [DATA_W-1:0] sig_o,
    output logic [ADDR_W-1:0] brk_addr_o,
    output logic [ADDR_W-1:0] ret_addr_o,
    output logic              ret_ok_o,
    output logic              act_valid_o,
    output logic [IDX_W-1:0]  act_idx_o
);
    logic              seq_done;
    logic [ADDR_W-1:0] w_brk, w_ret;
    logic [DATA_W-1:0] w_sig;
    logic              tbl_match;
    logic [IDX_W-1:0]  tbl_hit_idx;

    brk_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BRK_OP(8'h00), .STACK_PAGE(STACK_PAGE)
    ) seq_i (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_rnw(bus_rnw), .bus_sync(bus_sync),
        .done_o(seq_done), .brk_addr_o(w_brk), .sig_o(w_sig), .ret_addr_o(w_ret)
    );

    brk_match_table #(.N_ENT(N_ENT), .DATA_W(DATA_W), .IDX_W(IDX_W)) tbl_i (
        .clk(clk), .rst(rst),
        .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_sig(tbl_sig), .wr_on(tbl_on),
        .key(w_sig), .match_o(tbl_match), .idx_o(tbl_hit_idx)
    );

    // published outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o       <= 1'b0;
            sig_o       <= '0;
            brk_addr_o  <= '0;
            ret_addr_o  <= '0;
            ret_ok_o    <= 1'b0;
            act_valid_o <= 1'b0;
            act_idx_o   <= '0;
        end else begin
            hit_o       <= seq_done;
            act_valid_o <= seq_done && tbl_match;
            act_idx_o   <= (seq_done && tbl_match) ? tbl_hit_idx : '0;
            if (seq_done) begin
                sig_o      <= w_sig;
                brk_addr_o <= w_brk;
                ret_addr_o <= w_ret;
                ret_ok_o   <= (w_ret == w_brk + ADDR_W'(2));
            end
        end
    end

    AST_HIT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> !hit_o); // R4
    AST_HIT_AFTER_STACK_WRITE: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> $past(!bus_rnw && bus_addr[ADDR_W-1:DATA_W] == (ADDR_W-DATA_W)'(STACK_PAGE))); // R3
    AST_HELD_BETWEEN_HITS: assert property (@(posedge clk) disable iff (rst)
        !hit_o |-> $stable({sig_o, brk_addr_o, ret_addr_o, ret_ok_o})); // R5
    AST_ACT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        act_valid_o |-> hit_o); // R7
endmodule

// File: tb/brk_sig_snoop_tb_top.sv
module brk_sig_snoop_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_data = 8'hEA;
    logic        bus_rnw = 1'b1, bus_sync = 1'b0;
    logic        tbl_we = 1'b0, tbl_on = 1'b0;
    logic [2:0]  tbl_idx = 3'd0;
    logic [7:0]  tbl_sig = 8'h00;
    logic        hit_o, ret_ok_o, act_valid_o;
    logic [7:0]  sig_o;
    logic [15:0] brk_addr_o, ret_addr_o;
    logic [2:0]  act_idx_o;

    always #4 clk = ~clk;

    brk_sig_snoop dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_rnw(bus_rnw), .bus_sync(bus_sync), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_sig(tbl_sig), .tbl_on(tbl_on), .hit_o(hit_o), .sig_o(sig_o),
        .brk_addr_o(brk_addr_o), .ret_addr_o(ret_addr_o), .ret_ok_o(ret_ok_o),
        .act_valid_o(act_valid_o), .act_idx_o(act_idx_o)
    );

    int  n_chk = 0, n_err = 0;
    bit  finished = 0;
    logic [7:0] m_sig [8];
    logic       m_on  [8];

    // {break address, signature, pushed return address}
    localparam logic [39:0] VEC [6] = '{
        {16'h1234, 8'h5A, 16'h1236},
        {16'h8000, 8'h00, 16'h8002},
        {16'hFFFF, 8'hC3, 16'h0001},
        {16'h2000, 8'h11, 16'h2001},
        {16'h00FE, 8'hA5, 16'h0100},
        {16'h4321, 8'h7E, 16'h4323}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic cyc(input logic [15:0] a, input logic [7:0] d,
                       input logic rnw, input logic s);
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_rnw = rnw; bus_sync = s;
    endtask

    task automatic idle();
        cyc(16'h0000, 8'hEA, 1'b1, 1'b0);
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic pushes(input logic [15:0] ret);
        cyc(16'h01FD, ret[15:8], 1'b0, 1'b0);
        cyc(16'h01FC, ret[7:0], 1'b0, 1'b0);
        cyc(16'h01FB, 8'h34, 1'b0, 1'b0);
    endtask

    task automatic run_brk(input logic [15:0] ba, input logic [7:0] sg,
                           input logic [15:0] ret);
        cyc(ba, 8'h00, 1'b1, 1'b1);
        cyc(ba + 16'd1, sg, 1'b1, 1'b0);
        pushes(ret);
        tick();
    endtask

    task automatic tbl_set(input int idx, input logic [7:0] s, input logic on);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_sig = s; tbl_on = on;
        @(negedge clk);
        tbl_we = 1'b0;
        m_sig[idx] = s; m_on[idx] = on;
    endtask

    function automatic logic [3:0] exp_act(input logic [7:0] s);
        for (int i = 0; i < 8; i++)
            if (m_on[i] && m_sig[i] == s) return {1'b1, 3'(i)};
        return 4'b0000;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_sig[i] = 8'h00; m_on[i] = 1'b0; end
        repeat (5) @(posedge clk);
        #1;
        check("R9", "hit after reset", hit_o, 0);
        check("R9", "sig after reset", sig_o, 0);
        check("R9", "brk after reset", brk_addr_o, 0);
        check("R9", "ret after reset", ret_addr_o, 0);
        check("R9", "act after reset", act_valid_o, 0);
        @(negedge clk); rst = 1'b0;

        tbl_set(2, 8'h5A, 1'b1);
        tbl_set(5, 8'h5A, 1'b1);
        tbl_set(0, 8'hC3, 1'b0);
        tbl_set(7, 8'h7E, 1'b1);
        tbl_set(3, 8'h11, 1'b1);

        // R2 R6 R7 over the vector table
        for (int v = 0; v < 6; v++) begin
            logic [15:0] ba, ra;
            logic [7:0]  sg;
            logic [3:0]  ea;
            {ba, sg, ra} = VEC[v];
            ea = exp_act(sg);
            run_brk(ba, sg, ra);
            check("R4", "hit pulse", hit_o, 1);
            check("R2", "signature", sig_o, sg);
            check("R1", "break address", brk_addr_o, ba);
            check("R3", "return address", ret_addr_o, ra);
            check("R6", "return check", ret_ok_o, (ra == ba + 16'd2) ? 1 : 0);
            check("R7", "action valid", act_valid_o, ea[3]);
            check("R7", "action index", act_idx_o, ea[2:0]);
            idle(); tick();
            check("R4", "hit drops", hit_o, 0);
            check("R7", "action drops", act_valid_o, 0);
        end

        // R5: held while idle
        repeat (3) begin idle(); tick(); end
        check("R5", "sig held", sig_o, 8'h7E);
        check("R5", "ret held", ret_addr_o, 16'h4323);

        // R8: ordinary fetch aborts the sequence
        cyc(16'h3000, 8'h00, 1'b1, 1'b1);
        cyc(16'h3001, 8'h99, 1'b1, 1'b0);
        cyc(16'h01FD, 8'h30, 1'b0, 1'b0);
        cyc(16'h0040, 8'hEA, 1'b1, 1'b1);
        cyc(16'h01FC, 8'h02, 1'b0, 1'b0);
        cyc(16'h01FB, 8'h34, 1'b0, 1'b0);
        tick();
        check("R8", "no hit after abort", hit_o, 0);
        idle(); tick();
        check("R8", "no late hit", hit_o, 0);
        check("R8", "sig kept after abort", sig_o, 8'h7E);
        check("R8", "brk kept after abort", brk_addr_o, 16'h4321);

        // R8: a second break restarts the capture
        cyc(16'h3000, 8'h00, 1'b1, 1'b1);
        cyc(16'h3001, 8'h99, 1'b1, 1'b0);
        run_brk(16'h5000, 8'h42, 16'h5002);
        check("R8", "restart hit", hit_o, 1);
        check("R8", "restart brk", brk_addr_o, 16'h5000);
        check("R8", "restart sig", sig_o, 8'h42);

        // R1: non-break opcode fetch starts nothing
        cyc(16'h6000, 8'hEA, 1'b1, 1'b1);
        cyc(16'h6001, 8'h77, 1'b1, 1'b0);
        pushes(16'h6002);
        tick();
        check("R1", "no hit for other opcode", hit_o, 0);
        idle(); tick();
        check("R1", "sig unchanged", sig_o, 8'h42);

        // R3: stray write and read between pushes
        cyc(16'h7000, 8'h00, 1'b1, 1'b1);
        cyc(16'h7001, 8'h3C, 1'b1, 1'b0);
        cyc(16'h0200, 8'hFF, 1'b0, 1'b0);
        cyc(16'h01FD, 8'h70, 1'b0, 1'b0);
        cyc(16'h7002, 8'h55, 1'b1, 1'b0);
        cyc(16'h01FC, 8'h02, 1'b0, 1'b0);
        cyc(16'h01FB, 8'h34, 1'b0, 1'b0);
        tick();
        check("R3", "hit with gaps", hit_o, 1);
        check("R3", "ret with gaps", ret_addr_o, 16'h7002);
        check("R6", "ret ok with gaps", ret_ok_o, 1);
        check("R2", "sig with gaps", sig_o, 8'h3C);

        // R9: reset mid-run clears the table
        @(negedge clk); rst = 1'b1;
        bus_addr = 16'h0000; bus_data = 8'hEA; bus_rnw = 1'b1; bus_sync = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R9", "sig cleared", sig_o, 0);
        check("R9", "ret ok cleared", ret_ok_o, 0);
        @(negedge clk); rst = 1'b0;
        run_brk(16'h1234, 8'h5A, 16'h1236);
        check("R9", "hit after reset", hit_o, 1);
        check("R9", "table cleared", act_valid_o, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule